// File: doc/BRIEF.md
# Cascadable Display-Line Data Sampler

This block gathers one horizontal line of pixel values for a column driver that can sit in a chain of identical drivers. A word of three 6-bit pixel values arrives on each shift tick, which is a clock edge with `pix_valid` high. A start pulse arms the block. A one-hot pointer then walks through 103 groups of three channels and writes each accepted word into the line register at the group it points to. The block supports two scan directions. In each direction one of two bidirectional start/cascade pins is the start input and the other carries a one-tick pulse that arms the next driver in the chain. Once the last group is written the block stands by until a new start pulse arrives. A narrow mode skips three centre groups, giving a 300-channel line.

The pixel input is a valid/ready stream without back-pressure. Upstream broadcasts the same pixel stream to every driver in the chain and cannot stall. `pix_ready` only tells which ticks this block stores. A word offered while `pix_ready` is low is dropped and nothing else happens. A line-latch strobe ends the current line at any time. Analog conversion and output buffering are outside this block.

Top module: `line_sampler`

## Requirements
- R1: Synchronous active-low reset clears the pointer, the whole line register and both cascade outputs. After reset `pix_ready` is low.
- R2: A tick that samples the selected start pin high stores nothing and aims the pointer at the first group. `pix_ready` is high only when the pointer holds a group and the selected start pin is low. The first word is therefore stored on the first tick after the start pin falls.
- R3: A stored word goes to group g at `line_data[g*18 +: 18]`. Word bits [5:0], [11:6] and [17:12] feed channels 3g, 3g+1 and 3g+2 (0-based).
- R4: With `dir_up`=1, groups are written from 0 up to 102. With `dir_up`=0, they are written from 102 down to 0.
- R5: With `dir_up`=1, `a_in` is the start input and `b_out` is the cascade output: `b_oe`=1, `a_oe`=0, `a_out`=0. With `dir_up`=0 the pins swap roles: `a_oe`=1, `b_oe`=0, `b_out`=0.
- R6: The cascade output is high from the tick that moves the pointer onto the last group until the tick that stores that group. It is low on every other tick.
- R7: After the last group is stored, `pix_ready` stays low and further ticks leave `line_data` unchanged until a new start pulse.
- R8: With `narrow`=1, groups 50, 51 and 52 (0-based) are skipped in both directions, and their contents are kept. A line takes 100 words.
- R9: A `line_latch` strobe clears the pointer on that clock edge, whatever `pix_valid` is. Stored data is kept.
- R10: Clock edges with `pix_valid` low do not move the pointer and do not change `line_data`.
- R11: A start pulse in the middle of a line restarts loading from the first group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid | input | 1 | Shift tick / pixel word valid |
| pix_ready | output | 1 | Word on this tick will be stored |
| pix_data | input | 18 | Three 6-bit pixel values, bit 0 = LSB |
| dir_up | input | 1 | Scan direction, 1 = ascending |
| narrow | input | 1 | 300-channel mode, skips centre groups |
| line_latch | input | 1 | Line-latch strobe, clears pointer |
| a_in | input | 1 | Pin A input side |
| a_out | output | 1 | Pin A output side |
| a_oe | output | 1 | Pin A output enable |
| b_in | input | 1 | Pin B input side |
| b_out | output | 1 | Pin B output side |
| b_oe | output | 1 | Pin B output enable |
| line_data | output | 1854 | Line register, 309 channels of 6 bits |

## Verification
The bench builds the block with its default parameters: 103 groups of three 6-bit lanes, with the skip window at group 50 and three groups wide. Full-length lines are therefore checked in both directions, including both end groups, the cascade pulse on group 102 or group 0, and the jumps across the 49/53 boundary in narrow mode. Random words with random idle gaps are checked against a bench model of the group order. Directed cases cover a mid-line latch, a mid-line restart and words offered in standby.

// File: rtl/lds_pkg.sv
package lds_pkg;
  typedef enum logic {
    SCAN_DOWN = 1'b0,
    SCAN_UP   = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/lds_pointer.sv
// One-hot group pointer with direction and centre-skip next-state logic.
module lds_pointer #(
  parameter int GROUPS   = 103,
  parameter int SKIP_LO  = 50,
  parameter int SKIP_CNT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              clear,
  input  lds_pkg::scan_dir_e dir,
  input  logic              narrow,
  output logic [GROUPS-1:0] ptr,
  output logic              at_last
);
  localparam int SKIP_HI = SKIP_LO + SKIP_CNT - 1;
  localparam bit HAS_SKIP = (SKIP_CNT > 0);

  logic [GROUPS-1:0] first_oh, next_oh;
  logic              active;

  assign active = |ptr;

  always_comb begin
    first_oh = '0;
    if (dir == lds_pkg::SCAN_UP) first_oh[0] = 1'b1;
    else                         first_oh[GROUPS-1] = 1'b1;
  end

  always_comb begin
    if (dir == lds_pkg::SCAN_UP) begin
      next_oh = ptr << 1;
      if (HAS_SKIP && narrow && ptr[SKIP_LO-1]) begin
        next_oh = '0;
        next_oh[SKIP_HI+1] = 1'b1;
      end
    end else begin
      next_oh = ptr >> 1;
      if (HAS_SKIP && narrow && ptr[SKIP_HI+1]) begin
        next_oh = '0;
        next_oh[SKIP_LO-1] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)       ptr <= '0;
    else if (tick) begin
      if (start)               ptr <= first_oh;
      else if (active)         ptr <= next_oh;
    end
  end

  assign at_last = (dir == lds_pkg::SCAN_UP) ? ptr[GROUPS-1] : ptr[0];
endmodule

// File: rtl/lds_group_store.sv
// Line register: one word-wide slot per group, written when its pointer bit is set.
module lds_group_store #(
  parameter int GROUPS = 103,
  parameter int WORD_W = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [GROUPS-1:0]        sel,
  input  logic [WORD_W-1:0]        word,
  output logic [GROUPS*WORD_W-1:0] line
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                slot_q <= '0;
      else if (load && sel[g])   slot_q <= word;
    end
    assign line[g*WORD_W +: WORD_W] = slot_q;
  end
endmodule

// File: rtl/lds_pins.sv
// Start/cascade pin role selection for both scan directions.
module lds_pins (
  input  lds_pkg::scan_dir_e dir,
  input  logic a_in,
  input  logic b_in,
  input  logic cascade,
  output logic start,
  output logic a_out,
  output logic a_oe,
  output logic b_out,
  output logic b_oe
);
  logic up;
  assign up    = (dir == lds_pkg::SCAN_UP);
  assign start = up ? a_in : b_in;
  assign a_oe  = !up;
  assign b_oe  = up;
  assign a_out = !up && cascade;
  assign b_out = up && cascade;
endmodule

// File: rtl/line_sampler.sv
module line_sampler #(
  parameter int GROUPS   = 103,
  parameter int LANES    = 3,
  parameter int PIX_W    = 6,
  parameter int SKIP_LO  = 50,
  parameter int SKIP_CNT = 3,
  localparam int WORD_W  = LANES * PIX_W,
  localparam int LINE_W  = GROUPS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [WORD_W-1:0] pix_data,
  input  logic              dir_up,
  input  logic              narrow,
  input  logic              line_latch,
  input  logic              a_in,
  output logic              a_out,
  output logic              a_oe,
  input  logic              b_in,
  output logic              b_out,
  output logic              b_oe,
  output logic [LINE_W-1:0] line_data
);
  lds_pkg::scan_dir_e dir;
  logic [GROUPS-1:0]  ptr;
  logic               start_sel, at_last, store;

  assign dir       = dir_up ? lds_pkg::SCAN_UP : lds_pkg::SCAN_DOWN;
  assign pix_ready = (|ptr) && !start_sel;
  assign store     = pix_valid && pix_ready;

  lds_pins u_pins (
    .dir(dir), .a_in(a_in), .b_in(b_in), .cascade(at_last),
    .start(start_sel), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
  );

  lds_pointer #(.GROUPS(GROUPS), .SKIP_LO(SKIP_LO), .SKIP_CNT(SKIP_CNT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .tick(pix_valid), .start(start_sel),
    .clear(line_latch), .dir(dir), .narrow(narrow), .ptr(ptr), .at_last(at_last)
  );

  lds_group_store #(.GROUPS(GROUPS), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(store), .sel(ptr), .word(pix_data),
    .line(line_data)
  );
endmodule

// File: rtl/lds_checker.sv
module lds_checker #(
  parameter int LINE_W = 1854
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic              dir_up,
  input logic              line_latch,
  input logic              a_in,
  input logic              b_in,
  input logic              a_out,
  input logic              b_out,
  input logic              a_oe,
  input logic              b_oe,
  input logic [LINE_W-1:0] line_data
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!pix_ready && !a_out && !b_out && line_data == '0));

  p_ready_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> !(dir_up ? a_in : b_in));

  p_pins_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dir_up |-> (b_oe && !a_oe && !a_out));

  p_pins_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_up |-> (a_oe && !b_oe && !b_out));

  p_cascade_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_out || b_out) && (pix_valid || line_latch)) |=> !(a_out || b_out));

  p_latch_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_latch |=> !pix_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && pix_ready) |=> $stable(line_data));
endmodule

bind line_sampler lds_checker #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/tb_line_sampler.sv
module tb_line_sampler;
  localparam int G = 103;
  localparam int W = 18;

  logic clk = 0, rst_n = 0;
  logic pix_valid = 0, pix_ready;
  logic [W-1:0] pix_data = '0;
  logic dir_up = 1, narrow = 0, line_latch = 0;
  logic a_in = 0, b_in = 0, a_out, b_out, a_oe, b_oe;
  logic [G*W-1:0] line_data;

  logic [W-1:0] exp_g [G];
  int tot = 0, bad = 0;

  always #5 clk = ~clk;

  line_sampler dut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .dir_up(dir_up), .narrow(narrow), .line_latch(line_latch),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out),
    .b_oe(b_oe), .line_data(line_data)
  );

  function automatic int first_g(bit up);
    return up ? 0 : G - 1;
  endfunction

  function automatic int next_g(int g, bit up, bit nar);
    int n = up ? g + 1 : g - 1;
    if (nar && n >= 50 && n <= 52) n = up ? 53 : 49;
    if (n < 0 || n >= G) n = -1;
    return n;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic drive_start(bit v);
    a_in = dir_up ? v : 1'b0;
    b_in = dir_up ? 1'b0 : v;
  endtask

  task automatic cmp_line(string req);
    int badg = -1;
    for (int g = 0; g < G; g++)
      if (badg < 0 && line_data[g*W +: W] != exp_g[g]) badg = g;
    if (badg < 0) chk(1, req, "line", 0, 0);
    else chk(0, req, $sformatf("group %0d", badg), line_data[badg*W +: W], exp_g[badg]);
  endtask

  // Called at a negedge. Stops after abort_n words when abort_n >= 0.
  task automatic run_line(bit up, bit nar, int abort_n, string req);
    int g, n;
    logic [W-1:0] d;
    dir_up = up; narrow = nar;
    pix_valid = 1; pix_data = W'($urandom); drive_start(1);
    #1;
    chk(pix_ready == 0, "R2", "ready during start", pix_ready, 0);
    chk(up ? (b_oe && !a_oe) : (a_oe && !b_oe), "R5", "pin enables", {a_oe, b_oe}, up ? 1 : 2);
    @(negedge clk);
    g = first_g(up); n = 0;
    while (g >= 0) begin
      drive_start(0);
      if ($urandom % 4 == 0) begin
        pix_valid = 0; pix_data = W'($urandom);
        @(negedge clk);
        continue;
      end
      d = W'($urandom);
      pix_valid = 1; pix_data = d;
      #1;
      chk(pix_ready == 1, "R2", "ready while loading", pix_ready, 1);
      chk((up ? b_out : a_out) == (next_g(g, up, nar) < 0), "R6", "cascade pulse",
          up ? b_out : a_out, next_g(g, up, nar) < 0);
      @(negedge clk);
      exp_g[g] = d; n++;
      g = next_g(g, up, nar);
      if (abort_n >= 0 && n == abort_n) begin
        pix_valid = 0;
        return;
      end
    end
    pix_valid = 1; pix_data = W'($urandom);
    #1;
    chk(pix_ready == 0, "R7", "ready in standby", pix_ready, 0);
    chk(!a_out && !b_out, "R6", "cascade after line", {a_out, b_out}, 0);
    repeat (3) begin
      @(negedge clk);
      pix_data = W'($urandom);
    end
    pix_valid = 0;
    cmp_line(req);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] keep51;
    void'($urandom(32'h1d5a_77c3));
    for (int g = 0; g < G; g++) exp_g[g] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pix_ready == 0, "R1", "ready after reset", pix_ready, 0);
    chk(!a_out && !b_out, "R1", "cascade after reset", {a_out, b_out}, 0);
    chk(line_data == '0, "R1", "line after reset", line_data[63:0], 0);

    run_line(1, 0, -1, "R4 up R3");
    run_line(0, 0, -1, "R4 down R10");

    keep51 = exp_g[51];
    run_line(1, 1, -1, "R8 narrow up");
    chk(line_data[51*W +: W] == keep51, "R8", "skipped group kept", line_data[51*W +: W], keep51);
    run_line(0, 1, -1, "R8 narrow down");
    chk(line_data[51*W +: W] == keep51, "R8", "skipped group kept", line_data[51*W +: W], keep51);

    // R9: latch mid-line, then words offered must be dropped
    run_line(1, 0, 5, "R9");
    line_latch = 1;
    @(negedge clk);
    line_latch = 0; pix_valid = 1; pix_data = W'($urandom);
    #1;
    chk(pix_ready == 0, "R9", "ready after latch", pix_ready, 0);
    @(negedge clk);
    pix_valid = 0;
    cmp_line("R9");

    // R11: restart in the middle of a line
    run_line(0, 0, 20, "R11");
    run_line(0, 0, -1, "R11");

    for (int i = 0; i < 4; i++)
      run_line(1'($urandom), 1'($urandom), -1, "R3 random");

    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end
endmodule